// File: doc/BRIEF.md
# Parallel Video Capture Port with Sync Tracking

This block is the receive side of a parallel camera port. On every rising edge of the pixel clock it samples an 8-bit pixel bus together with two sync inputs. One sync marks the start of a line and the other marks the start of a frame. Each sync has its own polarity select, so a sensor that drives active-low syncs can be used as is. Only the change into the active level counts. How long a sync pulse stays active has no effect.

After each line-start edge the port puts a programmed number of samples on a valid/data stream. It marks the first sample of each frame and the last sample of each line. Samples that arrive after that quota and before the next line edge are dropped.

The port also checks sync timing by counting, with no check on pulse widths:
- It counts pixel-clock cycles from one line edge to the next and compares the count with a programmed line period.
- It counts line edges from one frame edge to the next and compares the count with a programmed frame length.

Any mismatch sets a sticky error bit in a 4-bit status output. Dropping the enable clears the status and parks the port.

Top module: `vidcap_port`

## Requirements
- R1: Both sync inputs are sampled on the rising clock edge and pass through two register stages. With the polarity select at 1 the high level is active; with it at 0 the low level is active. An active edge is the first cycle at the active level after a cycle at the inactive level. The width of the active pulse has no effect on the captured data or on the status.
- R2: A line edge starts a capture. The pixel sampled together with the first active line-sync level, and the pixels that follow it, appear in order on `out_valid`/`out_data`, up to `samp_count` samples. Later pixels are discarded. A new line edge that comes before the quota is reached ends the old capture and starts a new one.
- R3: `out_eol` is high with the sample that completes a line's `samp_count` quota. `out_sof` is high with the first sample of the first line whose edge falls on or after a frame edge.
- R4: The line period is the number of clock cycles between successive line edges. status[0] (line overflow) is set as soon as the cycles since the last line edge exceed `line_period`, including when line edges stop arriving. status[1] (line underflow) is set when a line edge arrives after fewer than `line_period` cycles.
- R5: Line edges are counted between frame edges. A line edge in the same cycle as a frame edge belongs to the new frame. status[2] (frame overflow) is set as soon as the count exceeds `frame_lines`. status[3] (frame underflow) is set when a frame edge arrives with a count below `frame_lines`.
- R6: The line checks start only after the first line edge seen after enable. The frame checks start only after the first frame edge seen after enable. A partial first line or frame therefore raises no error.
- R7: Status bits stay set while `en` is high. With `en` low, the status reads 0 and `out_valid` is low from the next clock on.
- R8: After a synchronous reset, `out_valid`, `out_sof`, `out_eol` and `status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Port enable; low clears status and stops capture |
| line_pol | input | 1 | Line-sync active level (1 = high, 0 = low) |
| frame_pol | input | 1 | Frame-sync active level (1 = high, 0 = low) |
| pix_in | input | 8 | Pixel data bus |
| line_sync_in | input | 1 | Line sync from the sensor |
| frame_sync_in | input | 1 | Frame sync from the sensor |
| line_period | input | 16 | Expected cycles between line edges |
| samp_count | input | 16 | Samples captured per line |
| frame_lines | input | 16 | Expected line edges per frame |
| out_valid | output | 1 | Captured sample present |
| out_data | output | 8 | Captured sample |
| out_sof | output | 1 | First sample of a frame |
| out_eol | output | 1 | Last sample of a line |
| status | output | 4 | Sticky errors: [0] line overflow, [1] line underflow, [2] frame overflow, [3] frame underflow |

## Verification
The bench uses sync pulses that range from one cycle to nearly a whole line, in both polarities, and checks that the stream and the status do not change with pulse width. A design that reacted to the level instead of the edge would restart captures and raise errors in this case. It programs a sample quota larger than the line. A design that did not restart on the new edge would merge lines or misplace the end-of-line mark.

It sets the line period and the frame length one above and one below the real values to check that overflow and underflow are separated. It stops the line syncs after the last line to confirm that overflow is reported during blanking. It also sends lines before the first frame edge, which a design that compared partial frames would flag by mistake.

// File: rtl/vidcap_pkg.sv
package vidcap_pkg;
  localparam int ST_W        = 4;
  localparam int ST_LINE_OF  = 0;
  localparam int ST_LINE_UF  = 1;
  localparam int ST_FRAME_OF = 2;
  localparam int ST_FRAME_UF = 3;
endpackage

// File: rtl/vidcap_sync.sv
module vidcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  input  logic pol_i,
  output logic edge_o
);
  logic [STAGES-1:0] st;

  // st[0] is the newest sample, normalised so that 1 means active
  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= {st[STAGES-2:0], ~(raw_i ^ pol_i)};
  end

  assign edge_o = st[STAGES-2] & ~st[STAGES-1];

  // an active edge can never be reported in two consecutive cycles
  assert_edge_single_R1: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);
endmodule

// File: rtl/vidcap_line_track.sv
module vidcap_line_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ledge,
  input  logic [CNT_W-1:0] period,
  output logic             line_of,
  output logic             line_uf
);
  logic [CNT_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt     <= '0;
      armed   <= 1'b0;
      line_of <= 1'b0;
      line_uf <= 1'b0;
    end else begin
      if (ledge) begin
        armed <= 1'b1;
        cnt   <= {{(CNT_W-1){1'b0}}, 1'b1};
        if (armed && cnt < period) line_uf <= 1'b1;
      end else if (cnt != {CNT_W{1'b1}}) begin
        cnt <= cnt + 1'b1;
      end
      if (armed && cnt > period) line_of <= 1'b1;
    end
  end

  assert_line_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (en && line_of && line_uf) |=> (line_of && line_uf) || (line_of || line_uf));
  assert_line_of_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (en && line_of) |=> line_of);
  assert_line_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!line_of && !line_uf));
  assert_line_unarmed_R6: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (!line_of && !line_uf));
  assert_uf_at_edge_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(line_uf) |-> $past(ledge));
endmodule

// File: rtl/vidcap_frame_track.sv
module vidcap_frame_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ledge,
  input  logic             fedge,
  input  logic [CNT_W-1:0] frame_lines,
  output logic             frame_of,
  output logic             frame_uf
);
  logic [CNT_W-1:0] lcnt;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      lcnt     <= '0;
      armed    <= 1'b0;
      frame_of <= 1'b0;
      frame_uf <= 1'b0;
    end else begin
      if (fedge) begin
        armed <= 1'b1;
        lcnt  <= {{(CNT_W-1){1'b0}}, ledge};
        if (armed && lcnt < frame_lines) frame_uf <= 1'b1;
      end else if (ledge && lcnt != {CNT_W{1'b1}}) begin
        lcnt <= lcnt + 1'b1;
      end
      if (armed && lcnt > frame_lines) frame_of <= 1'b1;
    end
  end

  assert_frame_of_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (en && frame_of) |=> frame_of);
  assert_frame_uf_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (en && frame_uf) |=> frame_uf);
  assert_frame_unarmed_R6: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (!frame_of && !frame_uf));
  assert_frame_uf_at_edge_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_uf) |-> $past(fedge));
endmodule

// File: rtl/vidcap_sampler.sv
module vidcap_sampler #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ledge,
  input  logic              fedge,
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  nsamp,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eol
);
  logic [CNT_W-1:0] remain;
  logic             sof_pend;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      remain    <= '0;
      sof_pend  <= 1'b0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_data  <= '0;
    end else if (ledge) begin
      sof_pend <= 1'b0;
      if (nsamp != '0) begin
        out_valid <= 1'b1;
        out_data  <= din;
        out_sof   <= sof_pend | fedge;
        out_eol   <= (nsamp == {{(CNT_W-1){1'b0}}, 1'b1});
        remain    <= nsamp - 1'b1;
      end else begin
        out_valid <= 1'b0;
        out_sof   <= 1'b0;
        out_eol   <= 1'b0;
        remain    <= '0;
      end
    end else begin
      sof_pend <= sof_pend | fedge;
      out_sof  <= 1'b0;
      if (remain != '0) begin
        out_valid <= 1'b1;
        out_data  <= din;
        out_eol   <= (remain == {{(CNT_W-1){1'b0}}, 1'b1});
        remain    <= remain - 1'b1;
      end else begin
        out_valid <= 1'b0;
        out_eol   <= 1'b0;
      end
    end
  end

  assert_marks_need_valid_R3: assert property (@(posedge clk) disable iff (rst)
    (out_sof || out_eol) |-> out_valid);
  assert_stream_stops_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !out_valid);
endmodule

// File: rtl/vidcap_port.sv
module vidcap_port
  import vidcap_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              line_pol,
  input  logic              frame_pol,
  input  logic [DATA_W-1:0] pix_in,
  input  logic              line_sync_in,
  input  logic              frame_sync_in,
  input  logic [CNT_W-1:0]  line_period,
  input  logic [CNT_W-1:0]  samp_count,
  input  logic [CNT_W-1:0]  frame_lines,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eol,
  output logic [ST_W-1:0]   status
);
  localparam int DLY = SYNC_STAGES - 1;

  logic ledge, fedge;
  logic line_of, line_uf, frame_of, frame_uf;
  logic [DATA_W-1:0] dpipe [DLY];

  vidcap_sync #(.STAGES(SYNC_STAGES)) u_line_sync (
    .clk(clk), .rst(rst), .raw_i(line_sync_in), .pol_i(line_pol), .edge_o(ledge));

  vidcap_sync #(.STAGES(SYNC_STAGES)) u_frame_sync (
    .clk(clk), .rst(rst), .raw_i(frame_sync_in), .pol_i(frame_pol), .edge_o(fedge));

  // pixel delay matched to the sync stages so data lines up with the edge
  for (genvar i = 0; i < DLY; i++) begin : g_dly
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) dpipe[i] <= '0;
        else     dpipe[i] <= pix_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) dpipe[i] <= '0;
        else     dpipe[i] <= dpipe[i-1];
      end
    end
  end

  vidcap_sampler #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sampler (
    .clk(clk), .rst(rst), .en(en), .ledge(ledge), .fedge(fedge),
    .din(dpipe[DLY-1]), .nsamp(samp_count),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol));

  vidcap_line_track #(.CNT_W(CNT_W)) u_line_track (
    .clk(clk), .rst(rst), .en(en), .ledge(ledge), .period(line_period),
    .line_of(line_of), .line_uf(line_uf));

  vidcap_frame_track #(.CNT_W(CNT_W)) u_frame_track (
    .clk(clk), .rst(rst), .en(en), .ledge(ledge), .fedge(fedge),
    .frame_lines(frame_lines), .frame_of(frame_of), .frame_uf(frame_uf));

  always_comb begin
    status              = '0;
    status[ST_LINE_OF]  = line_of;
    status[ST_LINE_UF]  = line_uf;
    status[ST_FRAME_OF] = frame_of;
    status[ST_FRAME_UF] = frame_uf;
  end
endmodule

// File: tb/vidcap_port_bench.sv
`timescale 1ns/1ps
module vidcap_port_bench;
  localparam int TRMAX = 4096;

  logic        clk = 1'b0;
  logic        rst, en, line_pol, frame_pol;
  logic [7:0]  pix_in;
  logic        line_sync_in, frame_sync_in;
  logic [15:0] line_period, samp_count, frame_lines;
  logic        out_valid, out_sof, out_eol;
  logic [7:0]  out_data;
  logic [3:0]  status;

  always #10 clk = ~clk;

  vidcap_port u_vidcap_port (
    .clk(clk), .rst(rst), .en(en), .line_pol(line_pol), .frame_pol(frame_pol),
    .pix_in(pix_in), .line_sync_in(line_sync_in), .frame_sync_in(frame_sync_in),
    .line_period(line_period), .samp_count(samp_count), .frame_lines(frame_lines),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol),
    .status(status));

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [7:0] tr_pix [TRMAX];
  logic       tr_l   [TRMAX];
  logic       tr_f   [TRMAX];
  int         ntr;
  logic [7:0] g_pix  [TRMAX];
  logic       g_sof  [TRMAX];
  logic       g_eol  [TRMAX];
  int         ngot;
  logic [7:0] e_pix  [TRMAX];
  logic       e_sof  [TRMAX];
  logic       e_eol  [TRMAX];
  int         nexp;

  always @(negedge clk) begin
    if (out_valid && ngot < TRMAX) begin
      g_pix[ngot] = out_data;
      g_sof[ngot] = out_sof;
      g_eol[ngot] = out_eol;
      ngot++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one pixel-clock cycle of stimulus, recorded in the trace
  task automatic step(input logic lact, input logic fact, input logic [7:0] p);
    @(negedge clk);
    line_sync_in  = lact ? line_pol  : ~line_pol;
    frame_sync_in = fact ? frame_pol : ~frame_pol;
    pix_in        = p;
    if (ntr < TRMAX) begin
      tr_pix[ntr] = p; tr_l[ntr] = lact; tr_f[ntr] = fact; ntr++;
    end
  endtask

  task automatic drive_line(input int gap, input int act, input bit fstart, input int fa);
    for (int i = 0; i < gap; i++)
      step(i < act, fstart && (i < fa), 8'($urandom_range(255, 0)));
  endtask

  // expected stream from the recorded active levels (R2, R3)
  task automatic build_expected(input int nsamp);
    logic pl, pf, pend, s;
    int rem;
    pl = 0; pf = 0; pend = 0; rem = 0; nexp = 0; s = 0;
    for (int c = 0; c < ntr; c++) begin
      logic lr, fr;
      lr = tr_l[c] & ~pl;
      fr = tr_f[c] & ~pf;
      if (fr) pend = 1;
      if (lr) begin rem = nsamp; s = pend; pend = 0; end
      if (rem > 0) begin
        e_pix[nexp] = tr_pix[c];
        e_sof[nexp] = lr ? s : 1'b0;
        e_eol[nexp] = (rem == 1);
        nexp++;
        rem--;
      end
      pl = tr_l[c]; pf = tr_f[c];
    end
  endtask

  task automatic run_scn(input string name, input int gap, input int nsamp, input int act,
                         input int nlines, input int nframes, input int pre, input int fa,
                         input logic lp, input logic fp, input int preg, input int freg,
                         input logic [3:0] exp_st);
    @(negedge clk);
    en = 0; line_pol = lp; frame_pol = fp;
    line_sync_in = ~lp; frame_sync_in = ~fp;
    line_period = 16'(preg); samp_count = 16'(nsamp); frame_lines = 16'(freg);
    repeat (4) @(negedge clk);
    ngot = 0; ntr = 0;
    en = 1;
    repeat (3) step(0, 0, 8'($urandom_range(255, 0)));
    for (int k = 0; k < pre; k++) drive_line(gap, act, 0, 0);
    for (int f = 0; f < nframes; f++)
      for (int l = 0; l < nlines; l++) drive_line(gap, act, l == 0, fa);
    // trailing frame and line edge closes the last periods
    step(1, 1, 8'($urandom_range(255, 0)));
    repeat (3) step(0, 0, 8'($urandom_range(255, 0)));
    check(status == exp_st, "R4/R5", {name, " status after last edge"}, status, exp_st);
    // blanking: line syncs stop, so line overflow must appear (R4)
    for (int i = 0; i < preg + gap + nsamp + 10; i++) step(0, 0, 8'($urandom_range(255, 0)));
    check(status == (exp_st | 4'b0001), "R4", {name, " overflow in blanking"},
          status, exp_st | 4'b0001);
    build_expected(nsamp);
    check(ngot == nexp, "R2", {name, " sample count"}, ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++)
      check(g_pix[i] == e_pix[i] && g_sof[i] == e_sof[i] && g_eol[i] == e_eol[i],
            "R2/R3", {name, " sample {sof,eol,data}"},
            {g_sof[i], g_eol[i], g_pix[i]}, {e_sof[i], e_eol[i], e_pix[i]});
    @(negedge clk); en = 0;
    @(negedge clk);
    check(status == 4'b0000, "R7", {name, " status cleared by enable"}, status, 0);
    check(out_valid == 1'b0, "R7", {name, " stream idle with enable low"}, out_valid, 0);
  endtask

  initial begin
    void'($urandom(32'h1f2e3d4c));
    rst = 1; en = 0; line_pol = 1; frame_pol = 1; pix_in = 0;
    line_sync_in = 0; frame_sync_in = 0;
    line_period = 20; samp_count = 8; frame_lines = 3;
    ngot = 0; ntr = 0; nexp = 0;
    repeat (3) @(negedge clk);
    check({out_valid, out_sof, out_eol} == 3'b000, "R8", "reset outputs",
          {out_valid, out_sof, out_eol}, 0);
    check(status == 4'b0000, "R8", "reset status", status, 0);
    rst = 0;

    run_scn("r1_basic",      20,  8,  3, 3, 2, 0,  5, 1, 1, 20, 3, 4'b0000);
    run_scn("r1_low_wide",   20,  8, 19, 3, 2, 0, 20, 0, 0, 20, 3, 4'b0000);
    run_scn("r4_short_line", 20,  6,  2, 3, 2, 0,  4, 1, 0, 21, 3, 4'b0010);
    run_scn("r4_long_line",  20,  6,  2, 3, 2, 0,  4, 0, 1, 19, 3, 4'b0001);
    run_scn("r5_many_lines", 16,  5,  1, 3, 2, 0,  2, 1, 1, 16, 2, 4'b0100);
    run_scn("r5_few_lines",  16,  5,  1, 3, 2, 0,  2, 1, 1, 16, 4, 4'b1000);
    run_scn("r2_truncate",   12, 15,  4, 2, 2, 0,  3, 1, 1, 12, 2, 4'b0000);
    run_scn("r6_partial",    14,  4,  2, 3, 2, 2,  3, 0, 1, 14, 3, 4'b0000);
    run_scn("r3_one_sample", 12,  1,  1, 2, 3, 0,  1, 1, 1, 12, 2, 4'b0000);

    for (int n = 0; n < 6; n++) begin
      int g, ns, a, nl, nf, pr, fa;
      logic lp, fp;
      g  = $urandom_range(40, 12);
      ns = $urandom_range(g, 1);
      a  = $urandom_range(g - 1, 1);
      nl = $urandom_range(4, 2);
      nf = $urandom_range(3, 2);
      pr = $urandom_range(2, 0);
      fa = $urandom_range(g, 1);
      lp = 1'($urandom_range(1, 0));
      fp = 1'($urandom_range(1, 0));
      run_scn("r1_random", g, ns, a, nl, nf, pr, fa, lp, fp, g, nl, 4'b0000);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule